// File: doc/BRIEF.md
# Four-Stage Pipelined Floating-Point Adder

This block adds two 60-bit floating-point operands in a pipeline of four registered stages. A pair of operands is presented with `in_valid`, and a new pair may be issued on every clock cycle. The sum leaves on `out_sum` together with `out_valid` four rising edges after the pair was captured.

The stage boundaries are chosen by gate depth per clock period, not by function. The first stage picks the operand with the larger exponent and shifts the other mantissa right in steps of eight. The second stage finishes the alignment with a shift of zero to seven bits and adds the lower half of the mantissas. The third stage adds the upper half using the registered carry. The fourth stage resolves the sign of a difference, takes any carry into the exponent and packs the word.

The result is not normalised; a separate unit does that. The only exception reported is exponent overflow.

Top module: `fadd4_pipe`

## Requirements
- R1: An operand word has the sign in bit 59, an 11-bit biased exponent in bits 58:48 and an unnormalised 48-bit integer mantissa in bits 47:0. It has the value (-1)^sign * mantissa * 2^(exponent - bias).
- R2: A new operand pair is accepted on every cycle in which `in_valid` is high, including back-to-back cycles, and each pair yields its own result.
- R3: `out_valid` is high in exactly the cycle after the fourth rising edge counted from the edge that captured a valid pair, and low for cycles in which no pair was issued.
- R4: The operand with the larger exponent sets the result exponent, and operand a counts as larger on a tie. The other mantissa is shifted right by the exponent difference and the bits shifted out are dropped. With like signs the result carries that sign and the sum of the mantissas.
- R5: When a like-sign sum carries out of 48 bits, the result mantissa is the 49-bit sum shifted right by one (the low bit is dropped) and the exponent is one higher.
- R6: `out_ovf` is 1 exactly when a carry occurs while the larger exponent is 2047; the exponent field then stays 2047. Otherwise `out_ovf` is 0.
- R7: With unlike signs the result mantissa is the absolute difference of the aligned mantissas. The sign is that of the operand whose aligned mantissa is larger. On exact cancellation the mantissa is zero and the sign and exponent are those of the larger-exponent operand.
- R8: No normalisation is applied: a difference with leading zeros keeps the larger exponent unchanged.
- R9: When the exponent difference exceeds 48, the result equals the larger-exponent operand bit for bit and `out_ovf` is 0.
- R10: An active-low asynchronous reset clears every stage valid, so `out_valid` is 0 during reset and until a pair issued after reset has passed all four stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_a | input | 60 | First operand |
| in_b | input | 60 | Second operand |
| out_valid | output | 1 | Result present |
| out_sum | output | 60 | Unnormalised sum |
| out_ovf | output | 1 | Exponent overflow on this result |

## Verification
The bench targets the seams where the logic is cut. If the low-half carry were lost or applied in the wrong cycle, mantissa sums would be off by 2^24. If the coarse and fine shifts were split wrongly, aligned mantissas would be off by a factor of a power of two. Subtractions where the smaller-exponent operand holds the larger aligned mantissa would come out with a flipped sign or an uncorrected two's-complement value if the final negation were wrong. The bench also covers a carry at the top exponent, which would wrap instead of flagging; exponent gaps of 49 and about 2000, which would leak shifted bits; and a reset in the middle of a stream, which would let stale valids escape.

// File: rtl/fadd_pkg.sv
package fadd_pkg;
  localparam int FA_EXP_W = 11;
  localparam int FA_MAN_W = 48;
  localparam int FA_STEP  = 8;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fa_op_e;
endpackage

// File: rtl/fadd_s1_align.sv
// Stage 1: pick larger exponent, form the shift, apply the coarse (multiple of STEP) part.
module fadd_s1_align import fadd_pkg::*; #(
  parameter int EXP_W = FA_EXP_W,
  parameter int MAN_W = FA_MAN_W,
  parameter int STEP  = FA_STEP
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [EXP_W+MAN_W:0]       in_a,
  input  logic [EXP_W+MAN_W:0]       in_b,
  output logic                       v_o,
  output logic                       xs_o,
  output fa_op_e                     op_o,
  output logic [EXP_W-1:0]           xe_o,
  output logic [MAN_W-1:0]           xm_o,
  output logic [MAN_W-1:0]           ym_o,
  output logic [$clog2(STEP)-1:0]    fine_o
);
  localparam int W      = 1 + EXP_W + MAN_W;
  localparam int SH_W   = $clog2(MAN_W + 1);
  localparam int FINE_W = $clog2(STEP);
  localparam logic [EXP_W-1:0] LIM = EXP_W'(MAN_W);

  logic              swap;
  logic [W-1:0]      x_w, y_w;
  logic [EXP_W-1:0]  diff;
  logic [SH_W-1:0]   sh, coarse;
  logic [MAN_W-1:0]  ym_n;
  logic [FINE_W-1:0] fine_n;
  fa_op_e            op_n;

  always_comb begin
    swap   = in_b[W-2:MAN_W] > in_a[W-2:MAN_W];
    x_w    = swap ? in_b : in_a;
    y_w    = swap ? in_a : in_b;
    diff   = x_w[W-2:MAN_W] - y_w[W-2:MAN_W];
    sh     = (diff > LIM) ? SH_W'(MAN_W) : diff[SH_W-1:0];
    coarse = sh & ~SH_W'(STEP - 1);
    ym_n   = y_w[MAN_W-1:0] >> coarse;
    fine_n = sh[FINE_W-1:0];
    op_n   = (x_w[W-1] ^ y_w[W-1]) ? OP_SUB : OP_ADD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      xs_o   <= x_w[W-1];
      op_o   <= op_n;
      xe_o   <= x_w[W-2:MAN_W];
      xm_o   <= x_w[MAN_W-1:0];
      ym_o   <= ym_n;
      fine_o <= fine_n;
    end
  end
endmodule

// File: rtl/fadd_s2_lo.sv
// Stage 2: fine shift of 0..STEP-1, then lower-half add with carry out.
module fadd_s2_lo import fadd_pkg::*; #(
  parameter int EXP_W = FA_EXP_W,
  parameter int MAN_W = FA_MAN_W,
  parameter int STEP  = FA_STEP
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          v_i,
  input  logic                          xs_i,
  input  fa_op_e                        op_i,
  input  logic [EXP_W-1:0]              xe_i,
  input  logic [MAN_W-1:0]              xm_i,
  input  logic [MAN_W-1:0]              ym_i,
  input  logic [$clog2(STEP)-1:0]       fine_i,
  output logic                          v_o,
  output logic                          xs_o,
  output fa_op_e                        op_o,
  output logic [EXP_W-1:0]              xe_o,
  output logic [MAN_W-MAN_W/2-1:0]      xh_o,
  output logic [MAN_W-MAN_W/2-1:0]      yh_o,
  output logic [MAN_W/2-1:0]            lo_o,
  output logic                          c_o
);
  localparam int LO_W = MAN_W / 2;

  logic [MAN_W-1:0] ymf, yo;
  logic [LO_W:0]    lo_sum;

  always_comb begin
    ymf    = ym_i >> fine_i;
    yo     = (op_i == OP_SUB) ? ~ymf : ymf;
    lo_sum = {1'b0, xm_i[LO_W-1:0]} + {1'b0, yo[LO_W-1:0]}
           + (LO_W+1)'(op_i == OP_SUB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      xs_o <= xs_i;
      op_o <= op_i;
      xe_o <= xe_i;
      xh_o <= xm_i[MAN_W-1:LO_W];
      yh_o <= yo[MAN_W-1:LO_W];
      lo_o <= lo_sum[LO_W-1:0];
      c_o  <= lo_sum[LO_W];
    end
  end
endmodule

// File: rtl/fadd_s3_hi.sv
// Stage 3: upper-half add using the registered carry; bit MAN_W flags carry (add) or negative (sub).
module fadd_s3_hi import fadd_pkg::*; #(
  parameter int EXP_W = FA_EXP_W,
  parameter int MAN_W = FA_MAN_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          v_i,
  input  logic                          xs_i,
  input  fa_op_e                        op_i,
  input  logic [EXP_W-1:0]              xe_i,
  input  logic [MAN_W-MAN_W/2-1:0]      xh_i,
  input  logic [MAN_W-MAN_W/2-1:0]      yh_i,
  input  logic [MAN_W/2-1:0]            lo_i,
  input  logic                          c_i,
  output logic                          v_o,
  output logic                          xs_o,
  output fa_op_e                        op_o,
  output logic [EXP_W-1:0]              xe_o,
  output logic [MAN_W:0]                r_o
);
  localparam int LO_W = MAN_W / 2;
  localparam int HI_W = MAN_W - LO_W;

  logic [HI_W:0]  hi_sum;
  logic [MAN_W:0] r_n;

  always_comb begin
    hi_sum = {1'b0, xh_i} + {1'b0, yh_i} + (HI_W+1)'(c_i);
    r_n    = {hi_sum[HI_W] ^ (op_i == OP_SUB), hi_sum[HI_W-1:0], lo_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      xs_o <= xs_i;
      op_o <= op_i;
      xe_o <= xe_i;
      r_o  <= r_n;
    end
  end
endmodule

// File: rtl/fadd_s4_pack.sv
// Stage 4: negate a negative difference, fold a carry into the exponent, pack.
module fadd_s4_pack import fadd_pkg::*; #(
  parameter int EXP_W = FA_EXP_W,
  parameter int MAN_W = FA_MAN_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_i,
  input  logic                     xs_i,
  input  fa_op_e                   op_i,
  input  logic [EXP_W-1:0]         xe_i,
  input  logic [MAN_W:0]           r_i,
  output logic                     v_o,
  output logic [EXP_W+MAN_W:0]     sum_o,
  output logic                     ovf_o
);
  logic             sub, neg, carry, emax, ovf_n, sign_n;
  logic [MAN_W-1:0] mag;
  logic [EXP_W-1:0] exp_n;

  always_comb begin
    sub    = (op_i == OP_SUB);
    neg    = sub & r_i[MAN_W];
    carry  = ~sub & r_i[MAN_W];
    emax   = &xe_i;
    if (neg)        mag = ~r_i[MAN_W-1:0] + MAN_W'(1);
    else if (carry) mag = r_i[MAN_W:1];
    else            mag = r_i[MAN_W-1:0];
    sign_n = neg ? ~xs_i : xs_i;
    ovf_n  = carry & emax;
    exp_n  = (carry & ~emax) ? xe_i + EXP_W'(1) : xe_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      sum_o <= {sign_n, exp_n, mag};
      ovf_o <= ovf_n;
    end
  end
endmodule

// File: rtl/fadd4_pipe.sv
module fadd4_pipe import fadd_pkg::*; #(
  parameter int EXP_W = FA_EXP_W,
  parameter int MAN_W = FA_MAN_W,
  parameter int STEP  = FA_STEP
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [EXP_W+MAN_W:0]   in_a,
  input  logic [EXP_W+MAN_W:0]   in_b,
  output logic                   out_valid,
  output logic [EXP_W+MAN_W:0]   out_sum,
  output logic                   out_ovf
);
  localparam int LO_W   = MAN_W / 2;
  localparam int HI_W   = MAN_W - LO_W;
  localparam int FINE_W = $clog2(STEP);

  logic              v1, xs1;
  fa_op_e            op1;
  logic [EXP_W-1:0]  xe1;
  logic [MAN_W-1:0]  xm1, ym1;
  logic [FINE_W-1:0] fine1;

  logic              v2, xs2, c2;
  fa_op_e            op2;
  logic [EXP_W-1:0]  xe2;
  logic [HI_W-1:0]   xh2, yh2;
  logic [LO_W-1:0]   lo2;

  logic              v3, xs3;
  fa_op_e            op3;
  logic [EXP_W-1:0]  xe3;
  logic [MAN_W:0]    r3;

  fadd_s1_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .STEP(STEP)) u_s1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .v_o(v1), .xs_o(xs1), .op_o(op1), .xe_o(xe1), .xm_o(xm1), .ym_o(ym1),
    .fine_o(fine1)
  );

  fadd_s2_lo #(.EXP_W(EXP_W), .MAN_W(MAN_W), .STEP(STEP)) u_s2 (
    .clk(clk), .rst_n(rst_n), .v_i(v1), .xs_i(xs1), .op_i(op1), .xe_i(xe1),
    .xm_i(xm1), .ym_i(ym1), .fine_i(fine1),
    .v_o(v2), .xs_o(xs2), .op_o(op2), .xe_o(xe2), .xh_o(xh2), .yh_o(yh2),
    .lo_o(lo2), .c_o(c2)
  );

  fadd_s3_hi #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_s3 (
    .clk(clk), .rst_n(rst_n), .v_i(v2), .xs_i(xs2), .op_i(op2), .xe_i(xe2),
    .xh_i(xh2), .yh_i(yh2), .lo_i(lo2), .c_i(c2),
    .v_o(v3), .xs_o(xs3), .op_o(op3), .xe_o(xe3), .r_o(r3)
  );

  fadd_s4_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_s4 (
    .clk(clk), .rst_n(rst_n), .v_i(v3), .xs_i(xs3), .op_i(op3), .xe_i(xe3),
    .r_i(r3), .v_o(out_valid), .sum_o(out_sum), .ovf_o(out_ovf)
  );
endmodule

// File: rtl/fadd4_chk.sv
module fadd4_chk #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 48
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [EXP_W+MAN_W:0] in_a,
  input logic [EXP_W+MAN_W:0] in_b,
  input logic                 out_valid,
  input logic [EXP_W+MAN_W:0] out_sum,
  input logic                 out_ovf
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [EXP_W-1:0] LIM = EXP_W'(MAN_W);

  logic [2:0]       since_rst;
  logic [W-1:0]     da [4];
  logic [W-1:0]     db [4];
  logic [EXP_W-1:0] ea, eb, ebig, gap, oe;
  logic [W-1:0]     larger;
  logic             far, aged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 3'd0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  always_ff @(posedge clk) begin
    da[0] <= in_a;
    db[0] <= in_b;
    for (int i = 1; i < 4; i++) begin
      da[i] <= da[i-1];
      db[i] <= db[i-1];
    end
  end

  always_comb begin
    ea     = da[3][W-2:MAN_W];
    eb     = db[3][W-2:MAN_W];
    ebig   = (eb > ea) ? eb : ea;
    larger = (eb > ea) ? db[3] : da[3];
    gap    = (eb > ea) ? eb - ea : ea - eb;
    far    = gap > LIM;
    aged   = since_rst >= 3'd4;
    oe     = out_sum[W-2:MAN_W];
  end

  // R3: result valid follows issue by four edges
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    aged |-> out_valid == $past(in_valid, 4));

  // R10: nothing leaves before a post-reset pair could arrive
  p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !aged |-> !out_valid);

  // R6: overflow only with a saturated exponent field
  p_ovf_exp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> &oe);

  // R9: far-apart exponents pass the larger operand through
  p_far_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (aged && out_valid && far) |-> (out_sum == larger && !out_ovf));

  // R4: like signs keep their sign
  p_like_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (aged && out_valid && da[3][W-1] == db[3][W-1]) |-> out_sum[W-1] == da[3][W-1]);

  // R8: exponent is the larger one, or one more after a carry
  p_exp_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (aged && out_valid && !out_ovf) |-> (oe == ebig || oe == ebig + EXP_W'(1)));
endmodule

bind fadd4_pipe fadd4_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_sum(out_sum), .out_ovf(out_ovf)
);

// File: tb/sim_fadd4_pipe.sv
module sim_fadd4_pipe;
  localparam int PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [59:0] in_a, in_b;
  logic        out_valid;
  logic [59:0] out_sum;
  logic        out_ovf;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic        qv [1:4];
  logic [60:0] qe [1:4];
  string       qt [1:4];

  fadd4_pipe u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_sum(out_sum), .out_ovf(out_ovf)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // R1: word layout sign | 11-bit exponent | 48-bit mantissa
  function automatic logic [59:0] pk(input logic s, input logic [10:0] e, input logic [47:0] m);
    return {s, e, m};
  endfunction

  // reference: {ovf, sum}
  function automatic logic [60:0] model(input logic [59:0] a, input logic [59:0] b);
    logic [59:0] x, y;
    logic [10:0] d;
    logic [47:0] xm, ym;
    logic [48:0] s;
    if (b[58:48] > a[58:48]) begin x = b; y = a; end
    else begin x = a; y = b; end
    d  = x[58:48] - y[58:48];
    xm = x[47:0];
    ym = (d > 11'd48) ? 48'd0 : (y[47:0] >> d);
    if (x[59] == y[59]) begin
      s = {1'b0, xm} + {1'b0, ym};
      if (s[48]) begin
        if (x[58:48] == 11'h7FF) return {1'b1, x[59], x[58:48], s[48:1]};
        else                     return {1'b0, x[59], x[58:48] + 11'd1, s[48:1]};
      end
      return {1'b0, x[59], x[58:48], s[47:0]};
    end
    if (xm >= ym) return {1'b0, x[59], x[58:48], xm - ym};
    return {1'b0, y[59], x[58:48], ym - xm};
  endfunction

  task automatic check_out();
    n_run++;
    if (out_valid !== qv[4]) begin
      n_fail++;
      $display("FAIL R3 out_valid actual=%b expected=%b", out_valid, qv[4]);
    end
    if (qv[4] === 1'b1) begin
      n_run++;
      if ({out_ovf, out_sum} !== qe[4]) begin
        n_fail++;
        $display("FAIL %s result actual=%h expected=%h", qt[4], {out_ovf, out_sum}, qe[4]);
      end
    end
  endtask

  task automatic step(input logic v, input logic [59:0] a, input logic [59:0] b, input string tag);
    @(negedge clk);
    check_out();
    for (int i = 4; i > 1; i--) begin
      qv[i] = qv[i-1]; qe[i] = qe[i-1]; qt[i] = qt[i-1];
    end
    qv[1] = v; qe[1] = model(a, b); qt[1] = tag;
    in_valid = v; in_a = a; in_b = b;
  endtask

  task automatic clear_q();
    for (int i = 1; i <= 4; i++) begin qv[i] = 1'b0; qe[i] = '0; qt[i] = "R3"; end
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    #1;
    n_run++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 out_valid in reset actual=%b expected=0", out_valid);
    end
    clear_q();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [59:0] rnd_op(input logic [10:0] e);
    logic [47:0] m;
    m = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    if ($urandom % 5 == 0) m = m >> ($urandom % 48);
    return pk(1'($urandom), e, m);
  endfunction

  initial begin
    void'($urandom(32'd7165));
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    clear_q();
    repeat (3) @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset state actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    step(1'b0, '0, '0, "R3");

    // R5: carry on equal exponents
    step(1'b1, pk(0, 11'd100, 48'hC000_0000_0000), pk(0, 11'd100, 48'hC000_0000_0001), "R5");
    // R6: carry at top exponent
    step(1'b1, pk(1, 11'h7FF, 48'h8000_0000_0000), pk(1, 11'h7FF, 48'h8000_0000_0000), "R6");
    // R7: b larger on tie, sign of b
    step(1'b1, pk(0, 11'd50, 48'd5), pk(1, 11'd50, 48'd9), "R7");
    // R7: exact cancellation keeps a's sign
    step(1'b1, pk(1, 11'd60, 48'd77), pk(0, 11'd60, 48'd77), "R7");
    // R7: smaller exponent with larger aligned mantissa
    step(1'b1, pk(0, 11'd20, 48'd1), pk(1, 11'd19, 48'h0000_0000_1000), "R7");
    // R8: leading zeros are kept
    step(1'b1, pk(0, 11'd300, 48'h8000_0000_0001), pk(1, 11'd300, 48'h8000_0000_0000), "R8");
    // R9: gap of 49 and about 2000
    step(1'b1, pk(1, 11'd10, 48'd123), pk(0, 11'd59, 48'hFFFF_FFFF_FFFF), "R9");
    step(1'b1, pk(0, 11'd2040, 48'h1234_5678_9ABC), pk(0, 11'd5, 48'hFFFF_FFFF_FFFF), "R9");
    // R4: alignment drops low bits, crosses the half-word carry
    step(1'b1, pk(0, 11'd500, 48'h0000_00FF_FFFF), pk(0, 11'd487, 48'hFFFF_FFFF_FFFF), "R4");
    step(1'b1, pk(1, 11'd77, 48'h0000_0100_0000), pk(1, 11'd90, 48'h0000_00FF_FFFF), "R4");
    // R2: back-to-back burst
    for (int i = 0; i < 8; i++)
      step(1'b1, pk(0, 11'd1000, 48'(i) << 20), pk(1, 11'(1000 - i), 48'h0F0F_0F0F_0F0F), "R2");
    step(1'b0, '0, '0, "R3");
    step(1'b0, '0, '0, "R3");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [10:0] ea, eb;
      logic [59:0] a, b;
      ea = 11'($urandom);
      if ($urandom % 8 == 0) eb = 11'($urandom);
      else eb = ea + 11'($urandom % 60) - 11'd30;
      a = rnd_op(ea);
      b = rnd_op(eb);
      step(1'($urandom % 4 != 0), a, b, (a[59] == b[59]) ? "R4" : "R7");
    end

    // R10: reset with pairs in flight
    step(1'b1, pk(0, 11'd3, 48'd3), pk(0, 11'd3, 48'd4), "R10");
    step(1'b1, pk(0, 11'd4, 48'd3), pk(0, 11'd3, 48'd4), "R10");
    pulse_reset();
    for (int i = 0; i < 6; i++) step(1'b0, '0, '0, "R10");
    step(1'b1, pk(1, 11'd9, 48'd9), pk(1, 11'd9, 48'd9), "R10");
    for (int i = 0; i < 6; i++) step(1'b0, '0, '0, "R3");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule